// File: doc/BRIEF.md
# ATM Receive Cell Delineator

This block takes the octet stream that has been pulled out of a SONET payload and finds the ATM cell boundaries in it. It does this by testing the header check sequence. While it is searching, it tests every octet offset. After a first match it confirms the boundary over a run of correctly spaced cells. From then on it tracks the boundary one cell at a time. Once locked, it validates every header and can repair a header that has a single-bit error. It removes the x^43+1 self-synchronizing scrambling from the 48 payload octets and throws away idle cells. Every other cell is passed on as a 53-octet burst with a start-of-cell marker, ready to be written into a receive cell FIFO.

Input octets arrive with a qualifier. Cycles in which the qualifier is low are gaps and are skipped completely. The delineation state and three saturating event counters are driven out as plain status outputs: corrected headers, discarded headers and removed idle cells. Each delivered octet leaves the block five input octets after it entered.

Top module: `atm_cell_rx`

## Requirements
- R1: After reset, sync_state_o is HUNT (0), all three counters read 0, and cell_vld_o and cell_soc_o are low.
- R2: In HUNT, a header check match at any octet offset moves the state to PRESYNC (1). A header check error in PRESYNC returns the state to HUNT. HUNT never leads directly to SYNC.
- R3: In PRESYNC, DELTA consecutive correct header checks at 53-octet spacing, counted after the one that left HUNT, enter SYNC (2). After DELTA-1 of them the state is still PRESYNC.
- R4: In SYNC, ALPHA consecutive header check errors return the state to HUNT. ALPHA-1 of them leave it in SYNC. SYNC never goes to PRESYNC.
- R5: A header is correct when its fifth octet equals the CRC-8 (generator x^8+x^2+x+1, message taken MSB first) of the four header octets, XORed with 0x55.
- R6: In SYNC and in correction mode, a header with exactly one wrong bit among its 40 bits is repaired. The cell is delivered with the corrected header and header check octet, corr_cnt_o increments, and detection mode is entered.
- R7: In SYNC, a cell is discarded, and drop_cnt_o increments, if its header error cannot be corrected or if it has any header error while in detection mode. Any errored header selects detection mode. A correct header selects correction mode.
- R8: Cells are delivered only when their header is checked in SYNC. A delivery is 53 consecutive valid octets: four header octets, the header check octet, then 48 payload octets. cell_soc_o is high with the first octet only.
- R9: An accepted cell whose header octets are 00 00 00 01 is not delivered, and idle_cnt_o increments.
- R10: Each of the 48 payload octets is descrambled MSB first as out = in XOR (received bit 43 bit-times earlier). The descrambler history spans cell boundaries and holds payload bits only. Header octets pass unchanged.
- R11: Each counter is CNT_W bits wide and holds at 2^CNT_W-1 instead of wrapping.
- R12: An input cycle with byte_vld_i low changes no state, output octet or phase, whatever the value on byte_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_i | input | 8 | Payload octet from the SONET deframer |
| byte_vld_i | input | 1 | byte_i carries a payload octet this cycle |
| cell_byte_o | output | 8 | Delivered cell octet |
| cell_vld_o | output | 1 | cell_byte_o is valid |
| cell_soc_o | output | 1 | First octet of a delivered cell |
| sync_state_o | output | 2 | Delineation state: 0 HUNT, 1 PRESYNC, 2 SYNC |
| corr_cnt_o | output | CNT_W | Saturating count of corrected headers |
| drop_cnt_o | output | CNT_W | Saturating count of discarded headers |
| idle_cnt_o | output | CNT_W | Saturating count of removed idle cells |

## Verification
The bench keeps DELTA=6 and ALPHA=7, so the exact PRESYNC and SYNC thresholds are tested one cell short of and at their limits. It sets CNT_W=4, which lets a run of twenty idle cells drive the idle counter into saturation, and keeps the corrected and discarded counters below their limit so that every individual step of those two counters is visible. Every delivered cell carries a sequence number in its header. The bench compares that number, the corrected header and the descrambled payload against an ordered list of the cells it expects. This makes spurious deliveries, lost cells and descrambler slips visible across loss of lock and relock.

// File: rtl/atm_rx_pkg.sv
package atm_rx_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HDR_BYTES  = 5;
  localparam int CW_BITS    = 8 * HDR_BYTES;
  localparam int SCR_LAG    = 43;
  localparam logic [7:0] HEC_COSET = 8'h55;
  localparam logic [31:0] IDLE_HDR = 32'h0000_0001;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } dl_state_e;

  // remainder of v(x)*x^8 modulo x^8+x^2+x+1, MSB first
  function automatic logic [7:0] crc_rem(input logic [CW_BITS-1:0] v);
    logic [7:0] r;
    logic fb;
    r = '0;
    for (int i = CW_BITS - 1; i >= 0; i--) begin
      fb = r[7] ^ v[i];
      r  = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction
endpackage

// File: rtl/atm_hec_check.sv
module atm_hec_check
  import atm_rx_pkg::*;
(
  input  logic [CW_BITS-1:0] cw_i,
  output logic               zero_o,
  output logic               fix_o,
  output logic [CW_BITS-1:0] cw_fix_o
);
  logic [7:0]         syn;
  logic [CW_BITS-1:0] flip;

  always_comb begin
    syn  = crc_rem(cw_i ^ {{(CW_BITS-8){1'b0}}, HEC_COSET});
    flip = '0;
    for (int p = 0; p < CW_BITS; p++) begin
      if (syn != 8'd0 && syn == crc_rem(CW_BITS'(1) << p)) flip[p] = 1'b1;
    end
  end

  assign zero_o   = (syn == 8'd0);
  assign fix_o    = |flip;
  assign cw_fix_o = cw_i ^ flip;
endmodule

// File: rtl/atm_delin_fsm.sv
module atm_delin_fsm
  import atm_rx_pkg::*;
#(
  parameter int DELTA = 6,
  parameter int ALPHA = 7,
  localparam int PW = $clog2(CELL_BYTES),
  localparam int GW = $clog2(DELTA + 1),
  localparam int EW = $clog2(ALPHA + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          hec_zero_i,
  input  logic          hec_fix_i,
  input  logic          idle_i,
  output dl_state_e     state_o,
  output logic [PW-1:0] phase_o,
  output logic          check_o,
  output logic          deliver_o,
  output logic          inc_corr_o,
  output logic          inc_drop_o,
  output logic          inc_idle_o
);
  dl_state_e     state_q, state_d;
  logic [PW-1:0] phase_q, phase_d;
  logic [GW-1:0] good_q, good_d;
  logic [EW-1:0] err_q, err_d;
  logic          detect_q, detect_d;
  logic          take;

  assign check_o = push_i && (state_q == ST_HUNT || phase_q == PW'(HDR_BYTES - 1));

  always_comb begin
    state_d    = state_q;
    good_d     = good_q;
    err_d      = err_q;
    detect_d   = detect_q;
    take       = 1'b0;
    inc_corr_o = 1'b0;
    inc_drop_o = 1'b0;
    phase_d    = phase_q;
    if (push_i) phase_d = (phase_q == PW'(CELL_BYTES - 1)) ? '0 : phase_q + 1'b1;
    if (check_o) begin
      unique case (state_q)
        ST_HUNT: if (hec_zero_i) begin
          state_d = ST_PRESYNC;
          good_d  = '0;
          phase_d = PW'(HDR_BYTES);
        end
        ST_PRESYNC: if (!hec_zero_i) begin
          state_d = ST_HUNT;
        end else if (good_q == GW'(DELTA - 1)) begin
          state_d  = ST_SYNC;
          err_d    = '0;
          detect_d = 1'b0;
        end else begin
          good_d = good_q + 1'b1;
        end
        default: if (hec_zero_i) begin
          err_d    = '0;
          detect_d = 1'b0;
          take     = 1'b1;
        end else begin
          if (err_q == EW'(ALPHA - 1)) state_d = ST_HUNT;
          else err_d = err_q + 1'b1;
          detect_d = 1'b1;
          if (!detect_q && hec_fix_i) begin
            take       = 1'b1;
            inc_corr_o = 1'b1;
          end else begin
            inc_drop_o = 1'b1;
          end
        end
      endcase
    end
  end

  assign inc_idle_o = take && idle_i;
  assign deliver_o  = take && !idle_i;
  assign state_o    = state_q;
  assign phase_o    = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      phase_q  <= '0;
      good_q   <= '0;
      err_q    <= '0;
      detect_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      good_q   <= good_d;
      err_q    <= err_d;
      detect_q <= detect_d;
    end
  end
endmodule

// File: rtl/atm_descrambler.sv
module atm_descrambler
  import atm_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  logic [SCR_LAG-1:0] hist_q, hist_d;

  always_comb begin
    hist_d = hist_q;
    for (int b = 7; b >= 0; b--) begin
      byte_o[b] = byte_i[b] ^ hist_d[SCR_LAG-1];
      hist_d    = {hist_d[SCR_LAG-2:0], byte_i[b]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else if (en_i) hist_q <= hist_d;
  end
endmodule

// File: rtl/atm_sat_cnt.sv
module atm_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (inc_i && cnt_o != {W{1'b1}}) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/atm_cell_rx.sv
module atm_cell_rx
  import atm_rx_pkg::*;
#(
  parameter int DELTA = 6,
  parameter int ALPHA = 7,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             byte_vld_i,
  output logic [7:0]       cell_byte_o,
  output logic             cell_vld_o,
  output logic             cell_soc_o,
  output logic [1:0]       sync_state_o,
  output logic [CNT_W-1:0] corr_cnt_o,
  output logic [CNT_W-1:0] drop_cnt_o,
  output logic [CNT_W-1:0] idle_cnt_o
);
  localparam int PW = $clog2(CELL_BYTES);

  logic [7:0]         win_q [HDR_BYTES];
  logic [CW_BITS-1:0] cw, cw_fix, hdr_q;
  logic               hec_zero, hec_fix, is_idle;
  dl_state_e          state;
  logic [PW-1:0]      phase, exit_idx;
  logic               check, deliver, dlv_q, desc_en;
  logic [2:0]         inc;
  logic [7:0]         desc_byte;

  always_comb begin
    cw = '0;
    for (int i = 1; i < HDR_BYTES; i++) cw = {cw[CW_BITS-9:0], win_q[i]};
    cw = {cw[CW_BITS-9:0], byte_i};
  end

  assign is_idle = (cw_fix[CW_BITS-1:8] == IDLE_HDR);

  atm_hec_check u_hec (
    .cw_i     (cw),
    .zero_o   (hec_zero),
    .fix_o    (hec_fix),
    .cw_fix_o (cw_fix)
  );

  atm_delin_fsm #(.DELTA(DELTA), .ALPHA(ALPHA)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (byte_vld_i),
    .hec_zero_i (hec_zero),
    .hec_fix_i  (hec_fix),
    .idle_i     (is_idle),
    .state_o    (state),
    .phase_o    (phase),
    .check_o    (check),
    .deliver_o  (deliver),
    .inc_corr_o (inc[0]),
    .inc_drop_o (inc[1]),
    .inc_idle_o (inc[2])
  );

  // index, within its cell, of the octet leaving the window
  assign exit_idx = (phase >= PW'(HDR_BYTES)) ? phase - PW'(HDR_BYTES)
                                              : phase + PW'(CELL_BYTES - HDR_BYTES);
  assign desc_en  = byte_vld_i && (exit_idx >= PW'(HDR_BYTES));

  atm_descrambler u_desc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (desc_en),
    .byte_i (win_q[0]),
    .byte_o (desc_byte)
  );

  logic [CNT_W-1:0] cnt [3];
  for (genvar g = 0; g < 3; g++) begin : g_cnt
    atm_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[g]),
      .cnt_o  (cnt[g])
    );
  end
  assign corr_cnt_o   = cnt[0];
  assign drop_cnt_o   = cnt[1];
  assign idle_cnt_o   = cnt[2];
  assign sync_state_o = state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < HDR_BYTES; i++) win_q[i] <= '0;
      hdr_q       <= '0;
      dlv_q       <= 1'b0;
      cell_byte_o <= '0;
      cell_vld_o  <= 1'b0;
      cell_soc_o  <= 1'b0;
    end else begin
      cell_vld_o <= byte_vld_i && dlv_q;
      cell_soc_o <= byte_vld_i && dlv_q && (exit_idx == '0);
      if (byte_vld_i) begin
        for (int i = 0; i < HDR_BYTES - 1; i++) win_q[i] <= win_q[i+1];
        win_q[HDR_BYTES-1] <= byte_i;
        cell_byte_o <= (exit_idx < PW'(HDR_BYTES))
                       ? hdr_q[CW_BITS-1-8*int'(exit_idx) -: 8] : desc_byte;
      end
      if (check) dlv_q <= deliver;
      if (deliver) hdr_q <= cw_fix;
    end
  end
endmodule

// File: rtl/atm_cell_rx_chk.sv
module atm_cell_rx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cell_vld_o,
  input logic             cell_soc_o,
  input logic [1:0]       sync_state_o,
  input logic [CNT_W-1:0] corr_cnt_o,
  input logic [CNT_W-1:0] drop_cnt_o,
  input logic [CNT_W-1:0] idle_cnt_o
);
  logic [5:0] nb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nb_q <= '0;
    else if (cell_vld_o) nb_q <= (nb_q == 6'd52) ? 6'd0 : nb_q + 6'd1;
  end

  AST_SOC_AT_CELL_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_soc_o |-> (cell_vld_o && nb_q == 6'd0)); // R8
  AST_CELL_START_HAS_SOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_vld_o && nb_q == 6'd0) |-> cell_soc_o); // R8
  AST_DELIVER_ONLY_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_vld_o |-> ($past(sync_state_o) == 2'd2)); // R8
  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_state_o != 2'd3); // R2
  AST_HUNT_NOT_TO_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_state_o == 2'd0) |=> (sync_state_o != 2'd2)); // R2
  AST_SYNC_NOT_TO_PRESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_state_o == 2'd2) |=> (sync_state_o != 2'd1)); // R4
  AST_CORR_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (corr_cnt_o == $past(corr_cnt_o) || corr_cnt_o == $past(corr_cnt_o) + 1'b1)); // R11
  AST_DROP_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (drop_cnt_o == $past(drop_cnt_o) || drop_cnt_o == $past(drop_cnt_o) + 1'b1)); // R11
  AST_IDLE_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (idle_cnt_o == $past(idle_cnt_o) || idle_cnt_o == $past(idle_cnt_o) + 1'b1)); // R11
endmodule

bind atm_cell_rx atm_cell_rx_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_atm_cell_rx.sv
module test_atm_cell_rx;
  localparam int CW = 4;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    byte_i = '0;
  logic          byte_vld_i = 1'b0;
  logic [7:0]    cell_byte_o;
  logic          cell_vld_o, cell_soc_o;
  logic [1:0]    sync_state_o;
  logic [CW-1:0] corr_cnt_o, drop_cnt_o, idle_cnt_o;

  always #2 clk_i = ~clk_i;

  atm_cell_rx #(.DELTA(6), .ALPHA(7), .CNT_W(CW)) i_atm_cell_rx (.*);

  int n_cmp = 0, n_err = 0;
  int next_seq = 0;
  logic [42:0] tx_st = '0;
  logic [CW-1:0] e_corr = '0, e_drop = '0, e_idle = '0;
  int exp_seq[$];
  string exp_tag[$];
  logic [7:0] rx_buf [53];
  int nb = 0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] sat(input logic [CW-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [7:0] hec_of(input logic [31:0] h);
    logic [7:0] r = '0;
    logic fb;
    for (int i = 31; i >= 0; i--) begin
      fb = r[7] ^ h[i];
      r  = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r ^ 8'h55;
  endfunction

  function automatic logic [31:0] data_hdr(input int seq);
    return {8'hA0, 16'(seq), 8'h02};
  endfunction

  function automatic logic [7:0] pay_byte(input int seq, input int i);
    return 8'(seq * 29 + i * 7) ^ 8'h5A;
  endfunction

  // R12: random gaps carry junk on byte_i
  task automatic put_byte(input logic [7:0] b);
    while ($urandom % 4 == 0) begin
      byte_vld_i = 1'b0;
      byte_i = 8'($urandom);
      @(negedge clk_i);
    end
    byte_i = b;
    byte_vld_i = 1'b1;
    @(negedge clk_i);
    byte_vld_i = 1'b0;
  endtask

  task automatic put_scr(input logic [7:0] p);
    logic [7:0] s;
    for (int b = 7; b >= 0; b--) begin
      s[b]  = p[b] ^ tx_st[42];
      tx_st = {tx_st[41:0], s[b]};
    end
    put_byte(s);
  endtask

  task automatic send_cell(input logic [31:0] hdr, input logic [39:0] err,
                           input bit zero_pay, input int seq, input bit idle);
    logic [39:0] cw = {hdr, hec_of(hdr)} ^ err;
    for (int k = 0; k < 5; k++) put_byte(cw[39-8*k -: 8]);
    for (int i = 0; i < 48; i++) begin
      if (zero_pay) put_byte(8'h00);
      else put_scr(idle ? 8'h6A : pay_byte(seq, i));
    end
  endtask

  task automatic tx_data(input logic [39:0] err, input bit exp_dlv, input string tag);
    if (exp_dlv) begin
      exp_seq.push_back(next_seq);
      exp_tag.push_back(tag);
    end
    send_cell(data_hdr(next_seq), err, 1'b0, next_seq, 1'b0);
    next_seq++;
  endtask

  task automatic tx_bad(input bit zero_pay);
    send_cell(data_hdr(next_seq), 40'hFF, zero_pay, next_seq, 1'b0);
    next_seq++;
  endtask

  task automatic tx_idle(input int n);
    for (int k = 0; k < n; k++) send_cell(32'h0000_0001, '0, 1'b0, 0, 1'b1);
  endtask

  task automatic chk_cnts(input string tag);
    chk({tag, " corr"}, 32'(corr_cnt_o), 32'(e_corr));
    chk({tag, " drop"}, 32'(drop_cnt_o), 32'(e_drop));
    chk({tag, " idle"}, 32'(idle_cnt_o), 32'(e_idle));
  endtask

  task automatic compare_cell();
    int seq, bad;
    string tag;
    logic [39:0] cw;
    logic [7:0] e, a;
    if (exp_seq.size() == 0) begin
      chk("R8 unexpected delivered cell", {24'd0, rx_buf[0]}, 32'hFFFF_FFFF);
      return;
    end
    seq = exp_seq.pop_front();
    tag = exp_tag.pop_front();
    cw = {data_hdr(seq), hec_of(data_hdr(seq))};
    bad = -1;
    e = '0;
    a = '0;
    for (int i = 0; i < 53; i++) begin
      logic [7:0] x = (i < 5) ? cw[39-8*i -: 8] : pay_byte(seq, i - 5);
      if (bad < 0 && rx_buf[i] !== x) begin
        bad = i;
        e = x;
        a = rx_buf[i];
      end
    end
    chk($sformatf("%s seq %0d byte %0d", tag, seq, bad), {24'd0, a}, {24'd0, e});
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && cell_vld_o) begin
      if (cell_soc_o) begin
        if (nb != 0) chk("R8 soc inside cell", 32'(nb), 32'd0);
        nb = 0;
      end
      rx_buf[nb] = cell_byte_o;
      nb++;
      if (nb == 53) begin
        compare_cell();
        nb = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk("R1 state in reset", 32'(sync_state_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 state", 32'(sync_state_o), 32'd0);
    chk("R1 valid", {30'd0, cell_vld_o, cell_soc_o}, 32'd0);
    chk_cnts("R1");

    for (int k = 0; k < 11; k++) put_byte(8'h00);
    chk("R2 stays HUNT on non-matching octets", 32'(sync_state_o), 32'd0);

    tx_data('0, 1'b0, "");
    chk("R2 R5 HUNT to PRESYNC", 32'(sync_state_o), 32'd1);
    for (int k = 0; k < 5; k++) tx_data('0, 1'b0, "");
    chk("R3 PRESYNC after DELTA-1", 32'(sync_state_o), 32'd1);
    tx_data('0, 1'b0, "");
    chk("R3 SYNC after DELTA", 32'(sync_state_o), 32'd2);

    for (int k = 0; k < 24; k++) begin
      if ($urandom % 4 == 0) begin
        tx_idle(1);
        e_idle = sat(e_idle);
      end else tx_data('0, 1'b1, "R8 R10 R12 random cell");
    end
    chk_cnts("R9 idle removal");

    tx_data(40'd1 << (8 + $urandom % 32), 1'b1, "R6 corrected header cell");
    e_corr = sat(e_corr);
    tx_data(40'd1 << ($urandom % 40), 1'b0, "");
    e_drop = sat(e_drop);
    chk_cnts("R7 detection mode discard");
    tx_data('0, 1'b1, "R7 return to correction");
    tx_data(40'h00_0000_0300, 1'b0, "");
    e_drop = sat(e_drop);
    tx_data('0, 1'b1, "R7 after double-bit discard");
    chk_cnts("R7 double-bit");
    tx_data(40'd1 << ($urandom % 8), 1'b1, "R6 corrected check octet cell");
    e_corr = sat(e_corr);
    tx_data('0, 1'b1, "R6 R10 cell after correction");
    chk_cnts("R6");

    for (int k = 0; k < 20; k++) begin
      tx_idle(1);
      e_idle = sat(e_idle);
    end
    chk("R11 idle counter saturates", 32'(idle_cnt_o), 32'(CMAX));
    chk_cnts("R11");

    for (int k = 0; k < 6; k++) begin
      tx_bad(1'b0);
      e_drop = sat(e_drop);
    end
    chk("R4 SYNC kept after ALPHA-1 errors", 32'(sync_state_o), 32'd2);
    tx_bad(1'b1);
    e_drop = sat(e_drop);
    chk("R4 HUNT after ALPHA errors", 32'(sync_state_o), 32'd0);
    chk_cnts("R4");

    tx_data('0, 1'b0, "");
    chk("R2 relock to PRESYNC", 32'(sync_state_o), 32'd1);
    tx_bad(1'b1);
    chk("R2 PRESYNC error to HUNT", 32'(sync_state_o), 32'd0);
    chk_cnts("R2 no count outside SYNC");

    for (int k = 0; k < 7; k++) tx_data('0, 1'b0, "");
    chk("R3 SYNC after relock", 32'(sync_state_o), 32'd2);
    for (int k = 0; k < 5; k++) tx_data('0, 1'b1, "R8 R10 cell after relock");
    tx_idle(3);
    chk("R11 idle counter holds", 32'(idle_cnt_o), 32'(CMAX));
    repeat (20) @(negedge clk_i);
    chk("R8 all expected cells delivered", 32'(exp_seq.size()), 32'd0);
    chk("R8 no partial cell", 32'(nb), 32'd0);
    summary();
    $finish;
  end
endmodule